// File: doc/BRIEF.md
# NAND Flash Host Interface with Hamming Parity Accumulator

This block lets a CPU drive an 8-bit NAND flash device through a small byte-wide register bus. One register moves bytes to and from the flash I/O lines, producing a single write-enable or read-enable strobe of configurable width per access. A second register drives the chip-enable, write-protect, address-latch and command-latch pins and reports the ready/busy pin. The remaining registers expose an error-correcting-code accumulator and let software clear it.

Every data byte that crosses the data register while neither latch pin is set is folded into row and column Hamming parity over a 256-byte chunk. Software clears the accumulator before a chunk, moves the chunk, and then reads a 16-bit line parity, a 6-bit column parity and a byte counter. It inverts these values to form the three stored code bytes. Correction, bad-block policy and command sequencing stay in software.

Bus protocol: the CPU raises `busReq` with the address, direction and write data held stable. It keeps them stable until `busAck` pulses for one cycle, and `busRdata` is valid while `busAck` is high.

Top module: `nand_ecc_host`

## Requirements
- R1: After reset, the chip-enable pins `nandCe0N` and `nandCe1N` are 1 (inactive), `nandWpN` is 0 (protected), `nandAle` and `nandCle` are 0, both strobes are high, `nandIoOe` is 0, and the parity and counter registers read 0.
- R2: The control register at offset 0x18 maps bit 0 to `nandCe0N`, bit 1 to `nandCle`, bit 2 to `nandAle`, bit 3 to `nandWpN` and bit 4 to `nandCe1N`. Reading it returns `nandRdy` in bit 5 and zeros in bits 7:6, and writes to bits 7:5 have no effect.
- R3: A write to the data register at offset 0x14 produces exactly one `nandWeN` low pulse of STROBE_CYCLES clocks. During that pulse `nandIoOe` is 1 and `nandIoOut` carries the written byte. `busAck` is seen STROBE_CYCLES+2 clocks after the request is accepted.
- R4: A read of the data register produces exactly one `nandReN` low pulse of STROBE_CYCLES clocks with `nandIoOe` at 0, and returns the value on `nandIoIn` in the last cycle of the pulse.
- R5: Column parity, read in bits 5:0 at offset 0x08, accumulates by XOR over all counted bytes. Bit 0 is the XOR of data bits 6,4,2,0, bit 1 of bits 7,5,3,1, bit 2 of bits 5,4,1,0, bit 3 of bits 7,6,3,2, bit 4 of bits 3..0 and bit 5 of bits 7..4.
- R6: Line parity is 16 bits, with bits 7:0 at offset 0x00 and bits 15:8 at 0x04. For each counted byte of odd bit parity and each k in 0..7, bit 2k+1 toggles if bit k of the byte's index within the chunk is 1, and bit 2k toggles otherwise.
- R7: The byte counter at offset 0x0C counts data bytes, is the index of the next byte, and wraps from 255 to 0, so it reads 0 after exactly 256 bytes.
- R8: Data bytes moved while `nandCle` or `nandAle` is 1 still produce a strobe but leave parity and counter unchanged.
- R9: Any write to offset 0x10 clears line parity, column parity and the counter.
- R10: Writes to offsets 0x00, 0x04, 0x08 and 0x0C are ignored. Reads of offset 0x10 and of any unmapped or unaligned address return 0.
- R11: Register (non-data) accesses are acknowledged one clock after acceptance and cause no flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Access request, held until acknowledge |
| busWrite | input | 1 | 1 = write access, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid with busAck |
| busAck | output | 1 | One-cycle access completion |
| nandIoOut | output | 8 | Byte driven toward the flash |
| nandIoIn | input | 8 | Byte returned by the flash |
| nandIoOe | output | 1 | Output enable for the flash I/O lines |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandCe0N | output | 1 | Chip enable 0, active low |
| nandCe1N | output | 1 | Chip enable 1, active low |
| nandWpN | output | 1 | Write protect, active low |
| nandAle | output | 1 | Address latch enable |
| nandCle | output | 1 | Command latch enable |
| nandRdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
On the 256th byte of a chunk, a single parity step both wraps the byte counter to zero and folds the byte into the line-parity bits selected by index 255, which are all the odd bits. A chunk-end carry or index error therefore shows up in both the counter and the parity at once. The bench provokes this by streaming full 256-byte chunks, first as writes and then as reads. It then compares the counter (expected 0) and both line-parity bytes against a bench model that keeps its own index count. A mid-chunk counter read and a single-byte case with hand-worked parity keep the two effects separable.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // index width of a byte inside a parity chunk (chunk = 2**CHUNK_BITS bytes)
  localparam int CHUNK_BITS = 8;
  localparam int LINE_W     = 2 * CHUNK_BITS;
  localparam int COL_W      = 6;

  // register index = byte address / 4
  typedef enum logic [2:0] {
    REG_LINE_LO = 3'd0,
    REG_LINE_HI = 3'd1,
    REG_COL     = 3'd2,
    REG_COUNT   = 3'd3,
    REG_CLEAR   = 3'd4,
    REG_DATA    = 3'd5,
    REG_CTL     = 3'd6,
    REG_NONE    = 3'd7
  } regSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    regLoad;      // capture selected register into read data
    logic    ctlWrite;     // update pin control register
    logic    eccClear;     // zero the accumulator
    logic    byteLoad;     // latch outgoing byte
    logic    byteCapture;  // latch incoming flash byte
    logic    eccStep;      // fold latched byte into the accumulator
    regSel_e sel;
  } hostStrobe_t;

endpackage

// File: rtl/nand_ecc_parity.sv
module nand_ecc_parity
  import nand_ecc_pkg::*;
(
  input  logic [7:0]            dataByte,
  input  logic [CHUNK_BITS-1:0] byteIdx,
  input  logic [LINE_W-1:0]     lineIn,
  input  logic [COL_W-1:0]      colIn,
  output logic [LINE_W-1:0]     lineOut,
  output logic [COL_W-1:0]      colOut
);

  logic byteOdd;
  logic [COL_W-1:0] colTerm;

  assign byteOdd = ^dataByte;

  // column terms: even/odd halves of single bits, pairs and nibbles
  assign colTerm[0] = ^(dataByte & 8'h55);
  assign colTerm[1] = ^(dataByte & 8'hAA);
  assign colTerm[2] = ^(dataByte & 8'h33);
  assign colTerm[3] = ^(dataByte & 8'hCC);
  assign colTerm[4] = ^(dataByte & 8'h0F);
  assign colTerm[5] = ^(dataByte & 8'hF0);

  assign colOut = colIn ^ colTerm;

  // line terms: one high/low pair per index bit
  for (genvar k = 0; k < CHUNK_BITS; k++) begin : g_line
    assign lineOut[2*k+1] = lineIn[2*k+1] ^ (byteOdd &  byteIdx[k]);
    assign lineOut[2*k]   = lineIn[2*k]   ^ (byteOdd & ~byteIdx[k]);
  end

endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int STROBE_CYCLES = 3,
  parameter int ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandIoOe,
  output hostStrobe_t       strb
);

  localparam int CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [ADDR_W-3:0] IDX_MAX = (ADDR_W-2)'(6);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_HOLD, S_ACK} state_e;

  state_e            state;
  logic [CNT_W-1:0]  pulseCnt;
  logic              opWrite;
  logic [ADDR_W-3:0] idxFull;
  logic              mapped;
  regSel_e           sel;
  logic              accept;
  logic              isData;
  logic              lastPulse;

  assign idxFull   = busAddr[ADDR_W-1:2];
  assign mapped    = (busAddr[1:0] == 2'b00) && (idxFull <= IDX_MAX);
  assign sel       = mapped ? regSel_e'(idxFull[2:0]) : REG_NONE;
  assign accept    = (state == S_IDLE) && busReq;
  assign isData    = (sel == REG_DATA);
  assign lastPulse = (pulseCnt == CNT_LAST);

  always_comb begin
    strb             = '0;
    strb.sel         = sel;
    strb.regLoad     = accept && !isData && !busWrite;
    strb.ctlWrite    = accept && busWrite && (sel == REG_CTL);
    strb.eccClear    = accept && busWrite && (sel == REG_CLEAR);
    strb.byteLoad    = accept && busWrite && isData;
    strb.byteCapture = (state == S_STROBE) && !opWrite && lastPulse;
    strb.eccStep     = (state == S_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pulseCnt <= '0;
      opWrite  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (busReq) begin
            if (isData) begin
              state    <= S_STROBE;
              opWrite  <= busWrite;
              pulseCnt <= '0;
            end else begin
              state <= S_ACK;
            end
          end
        end
        S_STROBE: begin
          if (lastPulse) state <= S_HOLD;
          else           pulseCnt <= pulseCnt + 1'b1;
        end
        S_HOLD:  state <= S_ACK;
        S_ACK:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busAck   = (state == S_ACK);
  assign nandWeN  = !((state == S_STROBE) && opWrite);
  assign nandReN  = !((state == S_STROBE) && !opWrite);
  assign nandIoOe = opWrite && ((state == S_STROBE) || (state == S_HOLD));

  // R4: the flash lines are never driven while reading
  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    nandIoOe |-> nandReN);

  // R3: write and read strobes never overlap
  p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R11: acknowledge lasts a single cycle
  p_ack_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R11: a register access causes no strobe
  p_reg_no_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !isData) |=> (nandWeN && nandReN && busAck));

endmodule

// File: rtl/nand_ecc_dpath.sv
module nand_ecc_dpath
  import nand_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hostStrobe_t strb,
  input  logic [7:0]  busWdata,
  input  logic [7:0]  nandIoIn,
  input  logic        nandRdy,
  output logic [7:0]  busRdata,
  output logic [7:0]  nandIoOut,
  output logic        nandCe0N,
  output logic        nandCe1N,
  output logic        nandWpN,
  output logic        nandAle,
  output logic        nandCle
);

  localparam logic [4:0] CTL_RESET = 5'b10001;

  logic [4:0]            ctlReg;
  logic [7:0]            ioByte;
  logic [LINE_W-1:0]     lineAcc, lineNext;
  logic [COL_W-1:0]      colAcc, colNext;
  logic [CHUNK_BITS-1:0] byteCount;
  logic                  eccGate;
  logic [7:0]            regMux;

  assign nandCe0N  = ctlReg[0];
  assign nandCle   = ctlReg[1];
  assign nandAle   = ctlReg[2];
  assign nandWpN   = ctlReg[3];
  assign nandCe1N  = ctlReg[4];
  assign nandIoOut = ioByte;

  // command and address bytes bypass the accumulator
  assign eccGate = strb.eccStep && !ctlReg[1] && !ctlReg[2];

  nand_ecc_parity uParity (
    .dataByte (ioByte),
    .byteIdx  (byteCount),
    .lineIn   (lineAcc),
    .colIn    (colAcc),
    .lineOut  (lineNext),
    .colOut   (colNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
    end else if (strb.ctlWrite) begin
      ctlReg <= busWdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioByte <= '0;
    end else if (strb.byteLoad) begin
      ioByte <= busWdata;
    end else if (strb.byteCapture) begin
      ioByte <= nandIoIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAcc   <= '0;
      colAcc    <= '0;
      byteCount <= '0;
    end else if (strb.eccClear) begin
      lineAcc   <= '0;
      colAcc    <= '0;
      byteCount <= '0;
    end else if (eccGate) begin
      lineAcc   <= lineNext;
      colAcc    <= colNext;
      byteCount <= byteCount + 1'b1;
    end
  end

  always_comb begin
    unique case (strb.sel)
      REG_LINE_LO: regMux = lineAcc[7:0];
      REG_LINE_HI: regMux = lineAcc[15:8];
      REG_COL:     regMux = {2'b00, colAcc};
      REG_COUNT:   regMux = byteCount;
      REG_CTL:     regMux = {2'b00, nandRdy, ctlReg};
      default:     regMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strb.regLoad) begin
      busRdata <= regMux;
    end else if (strb.byteCapture) begin
      busRdata <= nandIoIn;
    end
  end

  // R9: a clear leaves every accumulator field at zero
  p_clear_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.eccClear |=> (byteCount == '0 && lineAcc == '0 && colAcc == '0));

  // R8: steps taken under CLE or ALE leave the accumulator alone
  p_cmd_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eccStep && (nandCle || nandAle)) |=>
      ($stable(byteCount) && $stable(lineAcc) && $stable(colAcc)));

  // R7: each counted byte advances the index by one, modulo the chunk
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eccStep && !nandCle && !nandAle) |=>
      (byteCount == CHUNK_BITS'($past(byteCount) + 1'b1)));

  // R2: pin control only changes on a control write
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctlWrite |=> $stable(ctlReg));

endmodule

// File: rtl/nand_ecc_host.sv
module nand_ecc_host
  import nand_ecc_pkg::*;
#(
  parameter int STROBE_CYCLES = 3,
  parameter int ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busAck,
  output logic [7:0]        nandIoOut,
  input  logic [7:0]        nandIoIn,
  output logic              nandIoOe,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandCe0N,
  output logic              nandCe1N,
  output logic              nandWpN,
  output logic              nandAle,
  output logic              nandCle,
  input  logic              nandRdy
);

  hostStrobe_t strb;

  nand_ecc_ctrl #(
    .STROBE_CYCLES (STROBE_CYCLES),
    .ADDR_W        (ADDR_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busAck   (busAck),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandIoOe (nandIoOe),
    .strb     (strb)
  );

  nand_ecc_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .nandIoIn  (nandIoIn),
    .nandRdy   (nandRdy),
    .busRdata  (busRdata),
    .nandIoOut (nandIoOut),
    .nandCe0N  (nandCe0N),
    .nandCe1N  (nandCe1N),
    .nandWpN   (nandWpN),
    .nandAle   (nandAle),
    .nandCle   (nandCle)
  );

endmodule

// File: tb/nand_ecc_host_test.sv
module nand_ecc_host_test;

  localparam int STROBE = 3;
  localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_COL = 5'h08,
                         A_CNT = 5'h0C, A_CLR = 5'h10, A_DAT = 5'h14, A_CTL = 5'h18;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReq = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busAck;
  logic [7:0] nandIoOut;
  logic [7:0] nandIoIn = 8'h00;
  logic       nandIoOe, nandWeN, nandReN, nandCe0N, nandCe1N, nandWpN, nandAle, nandCle;
  logic       nandRdy = 1'b1;

  always #4 clk = ~clk;

  nand_ecc_host #(.STROBE_CYCLES(STROBE), .ADDR_W(5)) uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .nandIoOut(nandIoOut),
    .nandIoIn(nandIoIn), .nandIoOe(nandIoOe), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandCe0N(nandCe0N), .nandCe1N(nandCe1N), .nandWpN(nandWpN), .nandAle(nandAle),
    .nandCle(nandCle), .nandRdy(nandRdy)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] wrExpQ[$];
  bit         isRead = 0;

  // bench parity model, built from the requirement text
  logic [15:0] mLine = '0;
  logic [5:0]  mCol = '0;
  int          mCnt = 0;
  bit          mCle = 0, mAle = 0;
  int          wrCount = 0, wePulses = 0, rdIdx = 0;

  task automatic modelByte(input logic [7:0] b);
    if (mCle || mAle) return;
    if (^b) begin
      for (int k = 0; k < 8; k++) begin
        if (((mCnt >> k) & 1) == 1) mLine[2*k+1] = ~mLine[2*k+1];
        else                        mLine[2*k]   = ~mLine[2*k];
      end
    end
    mCol[0] = mCol[0] ^ b[6] ^ b[4] ^ b[2] ^ b[0];
    mCol[1] = mCol[1] ^ b[7] ^ b[5] ^ b[3] ^ b[1];
    mCol[2] = mCol[2] ^ b[5] ^ b[4] ^ b[1] ^ b[0];
    mCol[3] = mCol[3] ^ b[7] ^ b[6] ^ b[3] ^ b[2];
    mCol[4] = mCol[4] ^ b[3] ^ b[2] ^ b[1] ^ b[0];
    mCol[5] = mCol[5] ^ b[7] ^ b[6] ^ b[5] ^ b[4];
    mCnt = (mCnt + 1) % 256;
  endtask

  function automatic logic [7:0] flashByte(input int i);
    return 8'((i * 29 + 7) ^ (i >> 3));
  endfunction

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busWdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!busAck && lat < 1000);
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regWr(input logic [4:0] a, input logic [7:0] d);
    int lat;
    isRead = 0;
    access(1'b1, a, d, lat);
    check(lat == 1, "R11 write latency", lat, 1);
    if (a == A_CTL) begin mCle = d[1]; mAle = d[2]; end
    if (a == A_CLR) begin mLine = '0; mCol = '0; mCnt = 0; end
  endtask

  task automatic regRd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    int lat;
    expQ.push_back(exp); tagQ.push_back(tag);
    isRead = 1;
    access(1'b0, a, 8'h00, lat);
    check(lat == 1, "R11 read latency", lat, 1);
  endtask

  task automatic dataWr(input logic [7:0] d);
    int lat;
    wrExpQ.push_back(d);
    isRead = 0;
    wrCount++;
    access(1'b1, A_DAT, d, lat);
    check(lat == STROBE + 2, "R3 data write latency", lat, STROBE + 2);
    modelByte(d);
  endtask

  task automatic dataRd();
    int lat;
    logic [7:0] e;
    e = flashByte(rdIdx);
    rdIdx++;
    expQ.push_back(e); tagQ.push_back("R4 read data");
    isRead = 1;
    access(1'b0, A_DAT, 8'h00, lat);
    check(lat == STROBE + 2, "R4 data read latency", lat, STROBE + 2);
    modelByte(e);
  endtask

  task automatic eccCheck(input string tag);
    regRd(A_LLO, mLine[7:0], {tag, " line lo"});
    regRd(A_LHI, mLine[15:8], {tag, " line hi"});
    regRd(A_COL, {2'b00, mCol}, {tag, " column"});
    regRd(A_CNT, 8'(mCnt), {tag, " count"});
  endtask

  // monitor: compare read data on each acknowledge
  initial begin
    forever begin
      @(posedge busAck);
      #1;
      if (isRead) begin
        if (expQ.size() == 0) check(0, "scoreboard underrun", 0, 0);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(busRdata == e, t, busRdata, e);
        end
      end
    end
  end

  // flash model: write side
  int weLow = 0, reLow = 0, rdPtr = 0;
  always @(posedge clk) begin
    if (!nandWeN) weLow <= weLow + 1;
    if (!nandReN) reLow <= reLow + 1;
  end

  always @(posedge nandWeN) begin
    if (rstN) begin
      wePulses++;
      check(weLow == STROBE, "R3 write strobe width", weLow, STROBE);
      weLow = 0;
      check(nandIoOe == 1'b1, "R3 output enable", nandIoOe, 1);
      if (wrExpQ.size() > 0) begin
        logic [7:0] e;
        e = wrExpQ.pop_front();
        check(nandIoOut == e, "R3 flash byte", nandIoOut, e);
      end else check(0, "R3 unexpected write strobe", 0, 0);
    end
  end

  // flash model: read side
  always @(negedge nandReN) begin
    if (rstN) nandIoIn = flashByte(rdPtr);
  end

  always @(posedge nandReN) begin
    if (rstN) begin
      check(reLow == STROBE, "R4 read strobe width", reLow, STROBE);
      reLow = 0;
      check(nandIoOe == 1'b0, "R4 no drive on read", nandIoOe, 0);
      rdPtr++;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finishRun();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({nandCe0N, nandCe1N, nandWpN, nandAle, nandCle} == 5'b11000, "R1 reset pins",
          {nandCe0N, nandCe1N, nandWpN, nandAle, nandCle}, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);
    check({nandWeN, nandReN, nandIoOe} == 3'b110, "R1 reset strobes",
          {nandWeN, nandReN, nandIoOe}, 3'b110);
    regRd(A_CTL, 8'h31, "R1 control");
    regRd(A_LLO, 8'h00, "R1 line lo");
    regRd(A_LHI, 8'h00, "R1 line hi");
    regRd(A_COL, 8'h00, "R1 column");
    regRd(A_CNT, 8'h00, "R1 count");

    // control register mapping
    regWr(A_CTL, 8'hFF);
    nandRdy = 1'b0;
    regRd(A_CTL, 8'h1F, "R2 readback busy");
    check({nandCe1N, nandWpN, nandAle, nandCle, nandCe0N} == 5'b11111, "R2 pins all",
          {nandCe1N, nandWpN, nandAle, nandCle, nandCe0N}, 5'h1F);
    regWr(A_CTL, 8'h0A);
    check({nandCe1N, nandWpN, nandAle, nandCle, nandCe0N} == 5'b01010, "R2 pins cmd",
          {nandCe1N, nandWpN, nandAle, nandCle, nandCe0N}, 5'h0A);
    nandRdy = 1'b1;
    regRd(A_CTL, 8'h2A, "R2 readback ready");

    // command and address bytes bypass parity
    dataWr(8'h80);
    regWr(A_CTL, 8'h0C);
    dataWr(8'h00);
    dataWr(8'h12);
    regRd(A_CNT, 8'h00, "R8 count after cmd/addr");
    regRd(A_LLO, 8'h00, "R8 line after cmd/addr");
    regRd(A_COL, 8'h00, "R8 column after cmd/addr");

    // single byte, hand-worked parity
    regWr(A_CTL, 8'h08);
    dataWr(8'h01);
    regRd(A_LLO, 8'h55, "R6 single byte lo");
    regRd(A_LHI, 8'h55, "R6 single byte hi");
    regRd(A_COL, 8'h15, "R5 single byte");
    regRd(A_CNT, 8'h01, "R7 single byte");
    regWr(A_CLR, 8'h00);
    eccCheck("R9 after clear");

    // full chunk of writes
    for (int i = 0; i < 256; i++) begin
      dataWr(8'((i * 7 + 3) ^ 8'h5A));
      if (i == 99) regRd(A_CNT, 8'd100, "R7 mid chunk");
    end
    check(mCnt == 0, "R7 model wrap", mCnt, 0);
    eccCheck("R5 R6 R7 write chunk");

    // read-only registers ignore writes, unmapped reads return zero
    regWr(A_LLO, 8'hAB);
    regWr(A_CNT, 8'h77);
    regWr(A_COL, 8'hFF);
    eccCheck("R10 after ignored writes");
    regRd(5'h1C, 8'h00, "R10 unmapped");
    regRd(5'h19, 8'h00, "R10 unaligned");
    regRd(A_CLR, 8'h00, "R10 clear reads zero");

    // full chunk of reads
    regWr(A_CLR, 8'h00);
    for (int i = 0; i < 256; i++) dataRd();
    eccCheck("R5 R6 R7 read chunk");

    // clear in the middle of a chunk
    dataWr(8'hC3);
    dataWr(8'h7E);
    dataRd();
    regWr(A_CLR, 8'h00);
    eccCheck("R9 partial clear");

    repeat (4) @(negedge clk);
    check(wePulses == wrCount, "R11 strobe count", wePulses, wrCount);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    done = 1;
    finishRun();
  end

endmodule